// File: doc/BRIEF.md
# Audio Clock Divider with Fractional Master Clock

This block derives the two clocks an audio serial port needs from a single reference clock. The master clock comes from a period generator. It works either as a fractional divider or as a plain integer divider for older setups. The fractional divider takes a 16-bit integer ratio and a 16-bit fractional ratio. The integer divider takes an 8-bit field that holds half the period minus one. The bit clock is derived by counting master-clock periods. Both outputs are clock-enable style signals in the reference domain. The master clock is a level plus a one-cycle tick at the end of each period. The bit clock is a level that toggles on tick boundaries.

Software fills two 32-bit configuration words, and the fields are decoded before they reach this block. The frame word carries the sample width in bits 31:24, the transmit slot depth in 23:16, the bit-clock field in 15:8 and the receive depth or older master-clock field in 7:0. The fractional word carries the fractional part in bits 31:16 and the integer ratio in 15:0. Only the divider fields enter this block. The bit-clock field holds round(mclk / (bits × channels × fs × 2)) − 1.

The block contains three kinds of state machine. The master period generator has the states MC_OFF and MC_RUN. It goes from MC_OFF to MC_RUN on enable and back on disable. The bit divider has the states BC_OFF and BC_RUN. It goes from BC_OFF to BC_RUN when master mode and a live master clock are both present, and back when either is lost. Each ready sequencer has the states RDY_IDLE, RDY_SETTLE and RDY_LIVE. It goes from RDY_IDLE to RDY_SETTLE on enable. It goes from RDY_SETTLE to RDY_LIVE on the fourth output event. From any state it returns to RDY_IDLE on disable.

Top module: `acd_clock_gen`

## Requirements
- R1: In fractional mode each master period lasts I + c reference cycles. I is the integer ratio. The value c is the carry out of a 16-bit accumulator that adds the fractional ratio once per period. The accumulator is cleared while the master clock is disabled.
- R2: In fractional mode an integer ratio below 2 is treated as 2.
- R3: In integer (older) mode, selected by `legacy_i` = 1, each master period lasts 2 × (L + 1) reference cycles. L is the 8-bit older ratio field. The fractional and integer ratio inputs have no effect in this mode.
- R4: In every master period of P cycles, `mclk_o` is high for the first floor(P/2) cycles and low for the rest. `mclk_tick_o` is high for exactly the last cycle of the period.
- R5: A change to any master divider input never alters the period in progress. The new setting applies from the first period that starts after the change.
- R6: The bit clock toggles once every B + 1 master periods, where B is the bit-clock field. A change to B applies from the half period that starts after the next toggle.
- R7: The bit clock stays low unless both master mode and the master-clock enable are set. It returns low the cycle after either one is cleared.
- R8: `mclk_rdy_o` stays low until the fourth master tick after enable. It goes high in the cycle after that tick.
- R9: `bclk_rdy_o` goes high on the fourth rising edge of the bit clock after master mode is set. It stays low while master mode is off.
- R10: Each ready flag drops in the same cycle that its enable drops.
- R11: With `mclk_en_i` low, `mclk_o` and `mclk_tick_o` are low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| legacy_i | input | 1 | 1 selects the integer master divider |
| mclk_int_i | input | 16 | Integer master ratio (fractional mode) |
| mclk_frac_i | input | 16 | Fractional master ratio, units of 1/65536 |
| mclk_legacy_div_i | input | 8 | Older master field: half period minus one |
| bclk_div_i | input | 8 | Bit-clock field: master periods per half bit period, minus one |
| mclk_en_i | input | 1 | Master-clock enable |
| master_en_i | input | 1 | Master mode: drive the bit clock |
| mclk_o | output | 1 | Master-clock level |
| mclk_tick_o | output | 1 | One-cycle pulse on the last cycle of each master period |
| bclk_o | output | 1 | Bit-clock level |
| mclk_rdy_o | output | 1 | Master clock settled |
| bclk_rdy_o | output | 1 | Bit clock settled |

## Verification
The bench steps the fractional accumulator through a full carry cycle. A design that dropped or doubled the carry would show a period one cycle off at the wrap. Integer ratios of 0 and 1 are checked to give a 2-cycle period, which a design without the clamp would break by producing back-to-back ticks. Divider changes are made in the middle of a period; a design that reloads at once would shorten or stretch that period and produce a runt. The ready flags are checked on the exact cycle around the fourth event and at disable. An off-by-one count or a registered clear would show up one cycle late.

// File: rtl/acd_pkg.sv
package acd_pkg;

    typedef enum logic {
        MC_OFF,
        MC_RUN
    } mc_state_e;

    typedef enum logic {
        BC_OFF,
        BC_RUN
    } bc_state_e;

    typedef enum logic [1:0] {
        RDY_IDLE,
        RDY_SETTLE,
        RDY_LIVE
    } rdy_state_e;

endpackage

// File: rtl/acd_mclk_div.sv
module acd_mclk_div
    import acd_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16,
    parameter int LDIV_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              legacy_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [LDIV_W-1:0] ldiv_i,
    output logic              mclk_o,
    output logic              tick_o,
    output logic              live_o
);
    localparam int PER_W = INT_W + 1;

    mc_state_e         st_q, st_d;
    logic [PER_W-1:0]  cnt_q, per_q, per_next;
    logic [FRAC_W-1:0] acc_q, acc_next;
    logic [FRAC_W:0]   sum;
    logic [INT_W-1:0]  int_eff;
    logic              wrap;

    // length of the next period, chosen at each boundary
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_i};
        int_eff = (int_i < INT_W'(2)) ? INT_W'(2) : int_i;
        if (legacy_i) begin
            per_next = PER_W'({ldiv_i, 1'b0}) + PER_W'(2);
            acc_next = acc_q;
        end else begin
            per_next = PER_W'(int_eff) + PER_W'(sum[FRAC_W]);
            acc_next = sum[FRAC_W-1:0];
        end
    end

    assign wrap = (st_q == MC_RUN) && (cnt_q == per_q - PER_W'(1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= MC_OFF;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MC_OFF: if (run_i)  st_d = MC_RUN;
            MC_RUN: if (!run_i) st_d = MC_OFF;
            default:            st_d = MC_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            per_q <= '0;
            acc_q <= '0;
        end else begin
            unique case (st_q)
                MC_OFF: begin
                    cnt_q <= '0;
                    if (run_i) begin
                        per_q <= per_next;
                        acc_q <= acc_next;
                    end else begin
                        per_q <= '0;
                        acc_q <= '0;
                    end
                end
                MC_RUN: begin
                    if (!run_i) begin
                        cnt_q <= '0;
                        per_q <= '0;
                        acc_q <= '0;
                    end else if (wrap) begin
                        cnt_q <= '0;
                        per_q <= per_next;
                        acc_q <= acc_next;
                    end else begin
                        cnt_q <= cnt_q + PER_W'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                    per_q <= '0;
                    acc_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        live_o = (st_q == MC_RUN);
        tick_o = wrap;
        mclk_o = (st_q == MC_RUN) && (cnt_q < (per_q >> 1));
    end

endmodule

// File: rtl/acd_bclk_div.sv
module acd_bclk_div
    import acd_pkg::*;
#(
    parameter int BDIV_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              mtick_i,
    input  logic [BDIV_W-1:0] div_i,
    output logic              bclk_o,
    output logic              rise_o
);
    bc_state_e         st_q, st_d;
    logic [BDIV_W-1:0] cnt_q, lim_q;
    logic              lvl_q;
    logic              flip;

    assign flip = (st_q == BC_RUN) && run_i && mtick_i && (cnt_q == lim_q);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= BC_OFF;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BC_OFF: if (run_i)  st_d = BC_RUN;
            BC_RUN: if (!run_i) st_d = BC_OFF;
            default:            st_d = BC_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            lim_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            unique case (st_q)
                BC_OFF: begin
                    cnt_q <= '0;
                    lim_q <= div_i;
                    lvl_q <= 1'b0;
                end
                BC_RUN: begin
                    if (!run_i) begin
                        cnt_q <= '0;
                        lvl_q <= 1'b0;
                    end else if (flip) begin
                        cnt_q <= '0;
                        lim_q <= div_i;
                        lvl_q <= ~lvl_q;
                    end else if (mtick_i) begin
                        cnt_q <= cnt_q + BDIV_W'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                    lvl_q <= 1'b0;
                end
            endcase
        end
    end

    always_comb begin
        bclk_o = lvl_q;
        rise_o = flip && !lvl_q;
    end

endmodule

// File: rtl/acd_ready_fsm.sv
module acd_ready_fsm
    import acd_pkg::*;
#(
    parameter int SETTLE_N = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic evt_i,
    output logic rdy_o
);
    localparam int CW = $clog2(SETTLE_N + 1);

    rdy_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= RDY_IDLE;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RDY_IDLE:   if (en_i) st_d = RDY_SETTLE;
            RDY_SETTLE: begin
                if (!en_i)                                    st_d = RDY_IDLE;
                else if (evt_i && cnt_q == CW'(SETTLE_N - 1)) st_d = RDY_LIVE;
            end
            RDY_LIVE:   if (!en_i) st_d = RDY_IDLE;
            default:               st_d = RDY_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)                  cnt_q <= '0;
        else if (st_q != RDY_SETTLE)  cnt_q <= '0;
        else if (evt_i)               cnt_q <= cnt_q + CW'(1);
    end

    // flag clears combinationally with the enable
    always_comb begin
        rdy_o = (st_q == RDY_LIVE) && en_i;
    end

endmodule

// File: rtl/acd_clock_gen.sv
module acd_clock_gen #(
    parameter int INT_W    = 16,
    parameter int FRAC_W   = 16,
    parameter int LDIV_W   = 8,
    parameter int BDIV_W   = 8,
    parameter int SETTLE_N = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              legacy_i,
    input  logic [INT_W-1:0]  mclk_int_i,
    input  logic [FRAC_W-1:0] mclk_frac_i,
    input  logic [LDIV_W-1:0] mclk_legacy_div_i,
    input  logic [BDIV_W-1:0] bclk_div_i,
    input  logic              mclk_en_i,
    input  logic              master_en_i,
    output logic              mclk_o,
    output logic              mclk_tick_o,
    output logic              bclk_o,
    output logic              mclk_rdy_o,
    output logic              bclk_rdy_o
);
    logic mc_live, mc_tick, bc_rise, bc_run, bc_en;

    assign bc_en  = master_en_i && mclk_en_i;
    assign bc_run = bc_en && mc_live;

    acd_mclk_div #(
        .INT_W (INT_W),
        .FRAC_W(FRAC_W),
        .LDIV_W(LDIV_W)
    ) u_mclk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (mclk_en_i),
        .legacy_i(legacy_i),
        .int_i   (mclk_int_i),
        .frac_i  (mclk_frac_i),
        .ldiv_i  (mclk_legacy_div_i),
        .mclk_o  (mclk_o),
        .tick_o  (mc_tick),
        .live_o  (mc_live)
    );

    acd_bclk_div #(
        .BDIV_W(BDIV_W)
    ) u_bclk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (bc_run),
        .mtick_i(mc_tick),
        .div_i  (bclk_div_i),
        .bclk_o (bclk_o),
        .rise_o (bc_rise)
    );

    acd_ready_fsm #(
        .SETTLE_N(SETTLE_N)
    ) u_mrdy (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (mclk_en_i),
        .evt_i (mc_tick),
        .rdy_o (mclk_rdy_o)
    );

    acd_ready_fsm #(
        .SETTLE_N(SETTLE_N)
    ) u_brdy (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (bc_en),
        .evt_i (bc_rise),
        .rdy_o (bclk_rdy_o)
    );

    assign mclk_tick_o = mc_tick;

endmodule

// File: rtl/acd_clock_gen_chk.sv
module acd_clock_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic mclk_en_i,
    input logic master_en_i,
    input logic mclk_o,
    input logic mclk_tick_o,
    input logic bclk_o,
    input logic mclk_rdy_o,
    input logic bclk_rdy_o
);
    // R2: a period is never shorter than two cycles
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_tick_o |=> !mclk_tick_o);

    // R4: the last cycle of a period is in the low phase
    assert_tick_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mclk_tick_o |-> !mclk_o);

    // R6: the bit clock rises only at a master period boundary
    assert_bclk_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bclk_o) |-> $past(mclk_tick_o));

    // R8: master ready follows a tick
    assert_mrdy_after_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mclk_rdy_o) |-> $past(mclk_tick_o));

    // R9: bit ready implies master ready and master mode
    assert_brdy_needs_master_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_rdy_o |-> (mclk_rdy_o && master_en_i));

    // R11: disabled master clock goes quiet next cycle
    assert_mclk_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mclk_en_i |=> (!mclk_o && !mclk_tick_o));

endmodule

bind acd_clock_gen acd_clock_gen_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mclk_en_i  (mclk_en_i),
    .master_en_i(master_en_i),
    .mclk_o     (mclk_o),
    .mclk_tick_o(mclk_tick_o),
    .bclk_o     (bclk_o),
    .mclk_rdy_o (mclk_rdy_o),
    .bclk_rdy_o (bclk_rdy_o)
);

// File: tb/acd_clock_gen_tb_top.sv
`timescale 1ns/1ps
module acd_clock_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        legacy_i = 1'b0;
    logic [15:0] mclk_int_i = 16'd4;
    logic [15:0] mclk_frac_i = 16'd0;
    logic [7:0]  mclk_legacy_div_i = 8'd0;
    logic [7:0]  bclk_div_i = 8'd0;
    logic        mclk_en_i = 1'b0;
    logic        master_en_i = 1'b0;
    logic        mclk_o, mclk_tick_o, bclk_o, mclk_rdy_o, bclk_rdy_o;

    always #4 clk = ~clk;

    acd_clock_gen dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .legacy_i         (legacy_i),
        .mclk_int_i       (mclk_int_i),
        .mclk_frac_i      (mclk_frac_i),
        .mclk_legacy_div_i(mclk_legacy_div_i),
        .bclk_div_i       (bclk_div_i),
        .mclk_en_i        (mclk_en_i),
        .master_en_i      (master_en_i),
        .mclk_o           (mclk_o),
        .mclk_tick_o      (mclk_tick_o),
        .bclk_o           (bclk_o),
        .mclk_rdy_o       (mclk_rdy_o),
        .bclk_rdy_o       (bclk_rdy_o)
    );

    typedef struct {
        int    val;
        string tag;
    } exp_t;

    exp_t mq[$];
    exp_t bq[$];
    int   checks = 0;
    int   errors = 0;
    int   tick_total = 0;
    int   btog_total = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model of one master period
    function automatic int model_per(input bit leg, input int iv, input int fv,
                                     input int lv, inout int acc);
        int s;
        if (leg) return 2 * (lv + 1);
        s   = acc + fv;
        acc = s & 'hFFFF;
        return ((iv < 2) ? 2 : iv) + (s >> 16);
    endfunction

    // master-clock monitor
    int cyc = 0, hi = 0, msince = 0;
    bit mfirst = 1'b0, rdy_next = 1'b0;
    always @(negedge clk) begin
        if (!mclk_en_i || !rst_n) begin
            cyc = 0; hi = 0; msince = 0; mfirst = 1'b0; rdy_next = 1'b0;
        end else begin
            cyc++;
            if (mclk_o) hi++;
            if (rdy_next) begin
                chk(mclk_rdy_o == 1'b1, "R8 ready after 4th tick", int'(mclk_rdy_o), 1);
                rdy_next = 1'b0;
            end
            if (mclk_tick_o) begin
                msince++;
                tick_total++;
                if (msince == 4) begin
                    chk(mclk_rdy_o == 1'b0, "R8 ready low on 4th tick", int'(mclk_rdy_o), 0);
                    rdy_next = 1'b1;
                end
                if (!master_en_i)
                    chk(bclk_o == 1'b0 && bclk_rdy_o == 1'b0, "R7 R9 bclk idle without master",
                        int'({bclk_o, bclk_rdy_o}), 0);
                if (mfirst && mq.size() != 0) begin
                    exp_t e;
                    e = mq.pop_front();
                    chk(cyc == e.val, e.tag, cyc, e.val);
                    chk(hi == (e.val >> 1), "R4 high phase", hi, e.val >> 1);
                end
                mfirst = 1'b1;
                cyc = 0;
                hi = 0;
            end
        end
    end

    // bit-clock monitor
    int  bticks = 0, rises = 0;
    bit  bfirst = 1'b0, bprev = 1'b0;
    always @(negedge clk) begin
        if (!(master_en_i && mclk_en_i) || !rst_n) begin
            bticks = 0; rises = 0; bfirst = 1'b0; bprev = bclk_o;
        end else begin
            if (bclk_o != bprev) begin
                btog_total++;
                if (bfirst && bq.size() != 0) begin
                    exp_t e;
                    e = bq.pop_front();
                    chk(bticks == e.val, e.tag, bticks, e.val);
                end
                bfirst = 1'b1;
                bticks = 0;
                if (bclk_o) begin
                    rises++;
                    if (rises == 3) chk(bclk_rdy_o == 1'b0, "R9 low at 3rd rise", int'(bclk_rdy_o), 0);
                    if (rises == 4) chk(bclk_rdy_o == 1'b1, "R9 high at 4th rise", int'(bclk_rdy_o), 1);
                end
            end
            bprev = bclk_o;
            if (mclk_tick_o) bticks++;
        end
    end

    task automatic wait_mq_empty();
        while (mq.size() != 0) begin @(negedge clk); #1; end
    endtask

    task automatic stop_mclk();
        @(posedge clk); #1 mclk_en_i = 1'b0;
        @(negedge clk);
        chk(mclk_rdy_o == 1'b0, "R10 mclk ready drops with enable", int'(mclk_rdy_o), 0);
        @(negedge clk);
        chk(mclk_o == 1'b0 && mclk_tick_o == 1'b0, "R11 quiet after disable",
            int'({mclk_o, mclk_tick_o}), 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic run_mclk(input bit leg, input int iv, input int fv, input int lv,
                            input int n, input string tag);
        int acc = 0;
        int p;
        legacy_i = leg;
        mclk_int_i = 16'(iv);
        mclk_frac_i = 16'(fv);
        mclk_legacy_div_i = 8'(lv);
        for (int k = 1; k <= n; k++) begin
            p = model_per(leg, iv, fv, lv, acc);
            if (k > 1) mq.push_back('{p, tag});
        end
        @(posedge clk); #1 mclk_en_i = 1'b1;
        wait_mq_empty();
        stop_mclk();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : driver
        int base;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk({mclk_o, mclk_tick_o, bclk_o, mclk_rdy_o, bclk_rdy_o} == 5'b0,
            "R11 R7 reset state", int'({mclk_o, mclk_tick_o, bclk_o, mclk_rdy_o, bclk_rdy_o}), 0);

        // R7: master mode alone does not start the bit clock
        @(posedge clk); #1 master_en_i = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(bclk_o == 1'b0 && bclk_rdy_o == 1'b0, "R7 no bclk without mclk enable",
            int'({bclk_o, bclk_rdy_o}), 0);
        @(posedge clk); #1 master_en_i = 1'b0;

        run_mclk(1'b0, 4, 0, 0, 6, "R1 integer ratio 4");
        run_mclk(1'b0, 5, 'h4000, 0, 9, "R1 fraction quarter");
        run_mclk(1'b0, 3, 'hAAAA, 0, 8, "R1 fraction two thirds");
        run_mclk(1'b0, 0, 0, 0, 6, "R2 ratio zero clamps");
        run_mclk(1'b0, 1, 'h8000, 0, 7, "R2 ratio one with fraction");
        run_mclk(1'b1, 9, 'h8000, 2, 6, "R3 integer mode L=2");
        run_mclk(1'b1, 0, 'hFFFF, 0, 6, "R3 integer mode L=0");

        // R5: change the ratio in the middle of period 4
        legacy_i = 1'b0; mclk_int_i = 16'd6; mclk_frac_i = 16'd0;
        for (int k = 2; k <= 4; k++) mq.push_back('{6, "R5 old ratio holds"});
        for (int k = 5; k <= 8; k++) mq.push_back('{9, "R5 new ratio applies"});
        base = tick_total;
        @(posedge clk); #1 mclk_en_i = 1'b1;
        while (tick_total < base + 3) begin @(negedge clk); #1; end
        @(posedge clk);
        @(posedge clk); #1 mclk_int_i = 16'd9;
        wait_mq_empty();
        stop_mclk();

        // R6/R9: bit clock with a mid-run divider change
        mclk_int_i = 16'd4; bclk_div_i = 8'd1;
        @(posedge clk); #1 mclk_en_i = 1'b1;
        while (!mclk_rdy_o) begin @(negedge clk); #1; end
        for (int k = 2; k <= 5; k++) bq.push_back('{2, "R6 bclk half period B=1"});
        for (int k = 6; k <= 8; k++) bq.push_back('{4, "R6 bclk half period B=3"});
        base = btog_total;
        @(posedge clk); #1 master_en_i = 1'b1;
        while (btog_total < base + 4) begin @(negedge clk); #1; end
        bclk_div_i = 8'd3;
        while (bq.size() != 0) begin @(negedge clk); #1; end
        @(posedge clk); #1 master_en_i = 1'b0;
        @(negedge clk);
        chk(bclk_rdy_o == 1'b0 && mclk_rdy_o == 1'b1, "R10 bclk ready drops alone",
            int'({bclk_rdy_o, mclk_rdy_o}), 1);
        @(negedge clk);
        chk(bclk_o == 1'b0, "R7 bclk low after master off", int'(bclk_o), 0);
        stop_mclk();

        chk(mq.size() == 0 && bq.size() == 0, "R1 R6 all expected periods seen",
            mq.size() + bq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule